// File: doc/BRIEF.md
# CPU Low-Power Mode Controller

This block decides when the CPU core and the on-chip oscillators may run. Software writes a small power-control register. One bit asks for a light sleep (idle), one asks for a deep sleep (stop), and one enables a missing-clock watchdog. A sleep request takes hold only once the CPU reports that the instruction which wrote it has retired. In idle, the CPU and flash clock enables drop, while peripheral clocks and the oscillators keep going. An enabled interrupt then ends idle and execution resumes after the sleeping instruction. In stop, every enable drops, including the oscillator. Nothing but a reset brings the chip back, and the CPU then restarts from the reset vector.

The controller runs from an always-on reference clock that is independent of the system clock. A `sys_tick` strobe reports system clock activity. When the watchdog is enabled and no strobe arrives for `MCD_LIMIT` reference cycles, the block raises an internal reset. This ends a stop that software entered without first turning the watchdog off. Any reset request produces a fixed-length reset pulse, returns the register to its default, and records the cause of the last wake.

Top module: `pmc_top`

## Requirements
- R1: After `rst_n` is low for at least one clock, the following hold: `ctl_rd` reads 3'b100, all four enables are 1, `sys_rst` is 0, `wake_cause` is 0 and `wake_vec_sel` is 1.
- R2: Register bit 0 requests idle, bit 1 requests stop and bit 2 enables the watchdog. A write changes no enable; the mode is entered on the clock edge at which `retire` is high in a cycle after the write.
- R3: In idle, `cpu_clk_en` and `flash_clk_en` are 0 while `periph_clk_en` and `osc_en` stay 1.
- R4: In idle, an interrupt whose request and enable bits are both 1 clears bit 0 and returns all enables to 1 on the next edge. A request whose enable is 0 has no effect.
- R5: In stop, all four enables are 0, and interrupts, enabled or not, leave the mode and register unchanged.
- R6: When bits 0 and 1 are both written as 1, stop is entered.
- R7: Any reset request, in any mode, drives `sys_rst` high for exactly `RST_LEN` cycles starting on the next edge. On that same edge it puts the register back to 3'b100 and the block into run, and it sets `wake_vec_sel` to 1.
- R8: `wake_cause` takes one of these values: 1 for an interrupt wake, 2 for the external reset, 3 for the watchdog, 4 for the comparator reset and 5 for the convert-start reset. When several reset requests coincide, the lowest code among 2 to 5 wins. An interrupt wake also sets `wake_vec_sel` to 0.
- R9: With bit 2 set, `MCD_LIMIT` reference cycles without `sys_tick` cause an internal reset. With bit 2 clear, none is ever raised, even in stop.
- R10: Register writes made while in idle or stop are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ctl_wr | input | 1 | Power-control register write strobe |
| ctl_wdata | input | 3 | Write data: bit0 idle, bit1 stop, bit2 watchdog enable |
| ctl_rd | output | 3 | Register contents |
| retire | input | 1 | CPU instruction-retire strobe |
| irq_req | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Interrupt enables |
| ext_rst_req | input | 1 | External reset pin request, synchronized |
| cmp_rst_req | input | 1 | Comparator reset request |
| cnv_rst_req | input | 1 | Convert-start reset request |
| sys_tick | input | 1 | System clock activity strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Internal reset pulse |
| wake_vec_sel | output | 1 | 1 = restart at reset vector, 0 = resume |
| wake_cause | output | 3 | Cause of last wake |

## Verification
The bench models the oscillator by feeding `osc_en` back as `sys_tick`, so entering stop with the watchdog enabled really does starve the detector. A design that failed to gate the oscillator, or that counted the window wrongly, would wake early, wake late or never wake. Masked interrupts in idle and enabled interrupts in stop are both applied. A controller that ignored the enable mask would leave idle, and one that let interrupts end stop would wake from it. Coinciding reset requests check the cause priority. Writes made while asleep, and a requested sleep with no retire strobe yet, check that nothing changes before the instruction completes.

// File: rtl/pmc_pkg.sv
// Shared constants and types for the low-power mode controller.
package pmc_pkg;
    localparam int CTL_W    = 3;
    localparam int IDLE_BIT = 0;
    localparam int STOP_BIT = 1;
    localparam int MCD_BIT  = 2;
    localparam int NSRC     = 4;              // ext, watchdog, comparator, convert-start
    localparam logic [CTL_W-1:0] CTL_RESET = 3'b100;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_STOP = 2'd2
    } pm_state_t;

    typedef enum logic [2:0] {
        WC_NONE = 3'd0,
        WC_IRQ  = 3'd1,
        WC_EXT  = 3'd2,
        WC_MCD  = 3'd3,
        WC_CMP  = 3'd4,
        WC_CNV  = 3'd5
    } wake_cause_t;
endpackage

// File: rtl/pmc_mode_fsm.sv
// Power-control register and mode state machine.
// Assumes: rst_hold covers both a same-cycle reset request and an active reset
// pulse; retire marks completion of the instruction in flight.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_hold,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             retire,
    input  logic             irq_hit,
    output logic [CTL_W-1:0] ctl_q,
    output pm_state_t        state,
    output logic             irq_wake
);
    logic idle_q, stop_q, mcd_q;
    pm_state_t cur;

    // Register bits and mode transitions.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_hold) begin
            cur    <= PM_RUN;
            idle_q <= CTL_RESET[IDLE_BIT];
            stop_q <= CTL_RESET[STOP_BIT];
            mcd_q  <= CTL_RESET[MCD_BIT];
        end else begin
            case (cur)
                PM_RUN: begin
                    if (ctl_wr) begin
                        idle_q <= ctl_wdata[IDLE_BIT];
                        stop_q <= ctl_wdata[STOP_BIT];
                        mcd_q  <= ctl_wdata[MCD_BIT];
                    end
                    if (retire && stop_q)      cur <= PM_STOP;
                    else if (retire && idle_q) cur <= PM_IDLE;
                end
                PM_IDLE: begin
                    if (irq_hit) begin
                        cur    <= PM_RUN;
                        idle_q <= 1'b0;
                    end
                end
                default: cur <= PM_STOP;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ctl_q           = '0;
        ctl_q[IDLE_BIT] = idle_q;
        ctl_q[STOP_BIT] = stop_q;
        ctl_q[MCD_BIT]  = mcd_q;
        state           = cur;
        irq_wake        = (cur == PM_IDLE) && irq_hit && !rst_hold;
    end

    p_idle_needs_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PM_IDLE && $past(cur) == PM_RUN) |-> $past(retire));
    p_stop_only_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur) == PM_STOP && cur != PM_STOP) |-> $past(rst_hold));
    p_irq_clears_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PM_IDLE && irq_hit && !rst_hold) |=> (cur == PM_RUN && !idle_q));
    p_asleep_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != PM_RUN && !rst_hold && !irq_hit) |=> $stable({stop_q, mcd_q}));
endmodule

// File: rtl/pmc_miss_clk.sv
// Missing-clock detector: counts reference cycles since the last system clock
// strobe and trips when the window elapses. Assumes MCD_LIMIT >= 2.
module pmc_miss_clk #(
    parameter int MCD_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic clr,
    output logic trip
);
    localparam int CW = $clog2(MCD_LIMIT);
    localparam logic [CW-1:0] LAST = CW'(MCD_LIMIT - 1);

    logic [CW-1:0] cnt;

    // Silence counter, restarted by any activity, disable or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick || clr) cnt <= '0;
        else if (cnt != LAST)                 cnt <= cnt + 1'b1;
    end

    // Trip on the final silent cycle.
    always_comb trip = enable && !tick && !clr && (cnt == LAST);

    p_trip_after_silence_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> ($past(!tick) && $past(enable)));
    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt == '0);
endmodule

// File: rtl/pmc_reset_seq.sv
// Reset request combiner: stretches any request into a fixed-length pulse and
// keeps the wake cause and vector select. Assumes requests are synchronous.
module pmc_reset_seq
    import pmc_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [NSRC-1:0] req_vec,    // [0] ext, [1] watchdog, [2] cmp, [3] cnv
    input  logic        irq_wake,
    output logic        rst_req,
    output logic        sys_rst,
    output wake_cause_t cause,
    output logic        vec_sel
);
    localparam int RW = $clog2(RST_LEN + 1);

    logic [RW-1:0] cnt;
    wake_cause_t   cause_nxt;

    // Priority encode: lowest source index wins.
    always_comb begin
        rst_req   = |req_vec;
        cause_nxt = WC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_vec[i]) cause_nxt = wake_cause_t'(3'(i + 2));
        end
    end

    // Pulse stretcher.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (rst_req)    cnt <= RW'(RST_LEN);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Wake cause and restart vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause   <= WC_NONE;
            vec_sel <= 1'b1;
        end else if (rst_req) begin
            cause   <= cause_nxt;
            vec_sel <= 1'b1;
        end else if (irq_wake) begin
            cause   <= WC_IRQ;
            vec_sel <= 1'b0;
        end
    end

    always_comb sys_rst = (cnt != '0);

    p_req_starts_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> sys_rst);
    p_ext_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_vec[0] |=> cause == WC_EXT);
    p_irq_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wake && !rst_req) |=> (cause == WC_IRQ && !vec_sel));
endmodule

// File: rtl/pmc_top.sv
// Low-power mode controller top: wires the register/state machine, the
// missing-clock detector and the reset sequencer, and decodes the enables.
// Assumes clk is an always-on reference independent of the system clock.
module pmc_top
    import pmc_pkg::*;
#(
    parameter int NIRQ      = 2,
    parameter int MCD_LIMIT = 100,
    parameter int RST_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rd,
    input  logic             retire,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             ext_rst_req,
    input  logic             cmp_rst_req,
    input  logic             cnv_rst_req,
    input  logic             sys_tick,
    output logic             cpu_clk_en,
    output logic             flash_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             sys_rst,
    output logic             wake_vec_sel,
    output logic [2:0]       wake_cause
);
    logic            irq_hit, irq_wake, rst_req, mcd_trip, rst_hold;
    logic [CTL_W-1:0] ctl_q;
    logic [NSRC-1:0] req_vec;
    pm_state_t       state;
    wake_cause_t     cause;

    // Request gathering.
    always_comb begin
        irq_hit  = |(irq_req & irq_en);
        req_vec  = {cnv_rst_req, cmp_rst_req, mcd_trip, ext_rst_req};
        rst_hold = rst_req || sys_rst;
    end

    pmc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rst_hold(rst_hold),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .retire(retire),
        .irq_hit(irq_hit), .ctl_q(ctl_q), .state(state), .irq_wake(irq_wake)
    );

    pmc_miss_clk #(.MCD_LIMIT(MCD_LIMIT)) u_mcd (
        .clk(clk), .rst_n(rst_n), .enable(ctl_q[MCD_BIT]),
        .tick(sys_tick), .clr(sys_rst), .trip(mcd_trip)
    );

    pmc_reset_seq #(.RST_LEN(RST_LEN)) u_rst (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .irq_wake(irq_wake),
        .rst_req(rst_req), .sys_rst(sys_rst), .cause(cause), .vec_sel(wake_vec_sel)
    );

    // Enable decode per mode.
    always_comb begin
        cpu_clk_en    = (state == PM_RUN);
        flash_clk_en  = (state == PM_RUN);
        periph_clk_en = (state != PM_STOP);
        osc_en        = (state != PM_STOP);
        ctl_rd        = ctl_q;
        wake_cause    = cause;
    end

    p_stop_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PM_STOP && !$past(rst_hold)) |-> (!osc_en && !cpu_clk_en));
    p_idle_periph_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> (flash_clk_en == periph_clk_en ? 1'b0 : 1'b1) || !osc_en);
endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
    localparam int CLK_T = 10;
    localparam int LIM   = 40;
    localparam int RLEN  = 4;

    logic clk = 0, rst_n = 0;
    logic ctl_wr = 0, retire = 0, ext = 0, cmp = 0, cnv = 0, clk_ok = 1;
    logic [2:0] wdata = 0, ctl_rd, wake_cause;
    logic [1:0] irq_req = 0, irq_en = 0;
    logic cpu_en, fl_en, per_en, osc_en, sys_rst, vec_sel, sys_tick;
    int n_chk = 0, n_fail = 0;

    always #(CLK_T/2) clk = ~clk;
    assign sys_tick = osc_en && clk_ok;   // oscillator model

    pmc_top #(.NIRQ(2), .MCD_LIMIT(LIM), .RST_LEN(RLEN)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(wdata), .ctl_rd(ctl_rd),
        .retire(retire), .irq_req(irq_req), .irq_en(irq_en),
        .ext_rst_req(ext), .cmp_rst_req(cmp), .cnv_rst_req(cnv), .sys_tick(sys_tick),
        .cpu_clk_en(cpu_en), .flash_clk_en(fl_en), .periph_clk_en(per_en), .osc_en(osc_en),
        .sys_rst(sys_rst), .wake_vec_sel(vec_sel), .wake_cause(wake_cause)
    );

    // row: wr, wdata[3], retire, irq[2], ien[2] | en{cpu,fl,per,osc}[4], rd[3], req[4]
    localparam logic [19:0] VEC [8] = '{
        {1'b1, 3'b101, 1'b0, 2'b00, 2'b00, 4'b1111, 3'b101, 4'd2},  // R2 no entry yet
        {1'b0, 3'b000, 1'b1, 2'b00, 2'b00, 4'b0011, 3'b101, 4'd3},  // R3 idle
        {1'b0, 3'b000, 1'b0, 2'b01, 2'b00, 4'b0011, 3'b101, 4'd4},  // R4 masked
        {1'b1, 3'b110, 1'b1, 2'b00, 2'b00, 4'b0011, 3'b101, 4'd10}, // R10 write asleep
        {1'b0, 3'b000, 1'b0, 2'b01, 2'b01, 4'b1111, 3'b100, 4'd4},  // R4 wake
        {1'b1, 3'b111, 1'b0, 2'b00, 2'b00, 4'b1111, 3'b111, 4'd2},  // R2 write both
        {1'b0, 3'b000, 1'b1, 2'b00, 2'b00, 4'b0000, 3'b111, 4'd6},  // R6 stop wins
        {1'b0, 3'b000, 1'b0, 2'b11, 2'b11, 4'b0000, 3'b111, 4'd5}   // R5 irq ignored
    };

    task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wait_rst_done();
        for (int i = 0; i < 50 && sys_rst; i++) step();
    endtask

    task automatic count_to_rst(output int n);
        n = 0;
        for (int i = 0; i < 4*LIM && !sys_rst; i++) begin step(); n++; end
    endtask

    initial begin
        #(CLK_T * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic seen;
        repeat (3) step();
        rst_n = 1;
        // R1 reset state
        chk(1, "ctl_rd", ctl_rd, 3'b100);
        chk(1, "enables", {cpu_en, fl_en, per_en, osc_en}, 4'b1111);
        chk(1, "rst/vec/cause", {sys_rst, vec_sel, wake_cause}, {1'b0, 1'b1, 3'd0});

        for (int k = 0; k < 8; k++) begin
            {ctl_wr, wdata, retire, irq_req, irq_en} = VEC[k][19:11];
            step();
            {ctl_wr, wdata, retire, irq_req, irq_en} = '0;
            chk(int'(VEC[k][3:0]), "table enables", {cpu_en, fl_en, per_en, osc_en}, VEC[k][10:7]);
            chk(int'(VEC[k][3:0]), "table ctl_rd", ctl_rd, VEC[k][6:4]);
        end

        // R7 external reset out of stop
        ext = 1; step(); ext = 0;
        chk(7, "rst out of stop", {sys_rst, vec_sel, ctl_rd, cpu_en, fl_en, per_en, osc_en},
            {1'b1, 1'b1, 3'b100, 4'b1111});
        chk(8, "cause ext", wake_cause, 3'd2);
        n = 1;
        for (int i = 0; i < 20 && sys_rst; i++) begin step(); if (sys_rst) n++; end
        chk(7, "pulse length", n, RLEN);

        // R8 interrupt wake sets resume vector
        ctl_wr = 1; wdata = 3'b101; step(); ctl_wr = 0;
        retire = 1; step(); retire = 0;
        irq_req = 2'b10; irq_en = 2'b10; step(); irq_req = 0; irq_en = 0;
        chk(8, "irq cause/vec", {wake_cause, vec_sel}, {3'd1, 1'b0});
        chk(4, "irq clears idle", ctl_rd, 3'b100);

        // R8 priority
        cmp = 1; cnv = 1; step(); cmp = 0; cnv = 0;
        chk(8, "cmp over cnv", wake_cause, 3'd4);
        chk(7, "rst from run", {sys_rst, vec_sel}, 2'b11);
        wait_rst_done();
        ext = 1; cmp = 1; step(); ext = 0; cmp = 0;
        chk(8, "ext over cmp", wake_cause, 3'd2);
        wait_rst_done();

        // R9 watchdog ends stop
        ctl_wr = 1; wdata = 3'b110; step(); ctl_wr = 0;
        retire = 1; step(); retire = 0;
        chk(5, "stop enables", {cpu_en, fl_en, per_en, osc_en}, 4'b0000);
        count_to_rst(n);
        chk(9, "watchdog window", (n >= LIM-3 && n <= LIM+3), 1);
        chk(9, "cause mcd", wake_cause, 3'd3);
        wait_rst_done();

        // R9 disabled watchdog never trips
        ctl_wr = 1; wdata = 3'b010; step(); ctl_wr = 0;
        retire = 1; step(); retire = 0;
        seen = 0;
        for (int i = 0; i < 3*LIM; i++) begin step(); if (sys_rst) seen = 1; end
        chk(9, "no trip when disabled", seen, 0);
        chk(5, "still stopped", {cpu_en, osc_en, ctl_rd}, {2'b00, 3'b010});
        cnv = 1; step(); cnv = 0;
        chk(8, "cause cnv", wake_cause, 3'd5);
        chk(7, "awake after cnv", {cpu_en, fl_en, per_en, osc_en}, 4'b1111);
        wait_rst_done();

        // R9 clock loss while running
        clk_ok = 0;
        count_to_rst(n);
        clk_ok = 1;
        chk(9, "run clock loss", (n >= LIM-3 && n <= LIM+3), 1);
        chk(9, "cause mcd run", wake_cause, 3'd3);
        wait_rst_done();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule